// File: doc/BRIEF.md
# Trap Flag Register with Protected Bit Writes

This block holds the processor's trap flags: stack underflow, stack overflow, the non-maskable interrupt, and a parameterised set of class-B error flags such as an illegal-instruction trap. Hardware sources raise flags at any moment, unrelated to the instruction stream. Software reads the register, changes one bit or a field, and writes the result back a few cycles later. If the write-back used the stale read image for every bit, a flag that hardware raised between the read and the write could be wiped out, and that trap would be lost.

To prevent this, the write port carries a select mask next to the data. Only the selected bits take the written value. Every other bit keeps its live contents, including any flag that hardware raises in the write cycle itself. When a hardware set and a software clear hit the same bit in the same cycle, the set wins.

The non-maskable interrupt arrives as an asynchronous active-low pin. It passes through a synchronizer and a falling-edge detector, so each falling edge raises the flag exactly once. Two summary outputs report pending traps by class, and class A masks class B.

Top module: `trap_flag_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released, every flag reads 0 and both pending outputs are 0.
- R2: A one-cycle pulse on a hardware set input makes its flag read 1 after the next rising clock edge. The flag stays 1 until software writes that bit.
- R3: During a write, the bits not selected in `wr_sel` keep their current value. This holds even when `wr_data` carries a stale 0 for them, and it includes flags that hardware raises in the same cycle.
- R4: During a write, each bit selected in `wr_sel` takes the value of the same bit of `wr_data`, so software can both set and clear flags.
- R5: If a hardware set and a selected write of 0 to the same bit happen in the same cycle, the bit reads 1 afterwards.
- R6: A falling edge on `nmi_n` raises bit 2. The bit is still 0 after the second rising edge that follows the change and reads 1 after the third. Holding the pin low does not raise the bit again after software clears it. A rising edge has no effect.
- R7: `pend_a` is 1 exactly when at least one class-A flag is set. The class-A flags are bit 0 (stack underflow), bit 1 (stack overflow) and bit 2 (non-maskable interrupt).
- R8: `pend_b` is 1 exactly when at least one class-B flag is set and `pend_a` is 0. The class-B flags are bits 3 and up, and bit 3+i is set by `err_set[i]`.
- R9: While `wr_en` is 0, the values on `wr_sel` and `wr_data` have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_n | input | 1 | Asynchronous active-low non-maskable interrupt pin |
| stk_unf_set | input | 1 | Stack underflow set pulse (bit 0) |
| stk_ovf_set | input | 1 | Stack overflow set pulse (bit 1) |
| err_set | input | NUM_CLASSB | Class-B error set pulses (bit 3+i) |
| wr_en | input | 1 | Write phase strobe |
| wr_sel | input | 3+NUM_CLASSB | Mask of bits selected by the instruction |
| wr_data | input | 3+NUM_CLASSB | Value to write into selected bits |
| rd_data | output | 3+NUM_CLASSB | Current flag contents |
| pend_a | output | 1 | Class-A trap pending |
| pend_b | output | 1 | Class-B trap pending with no class-A flag set |

## Verification
The assertions assume that the hardware set inputs and the write strobe are synchronous to `clk` and are already held at defined levels during reset. They assume the non-maskable interrupt pin is the only source that changes bit 2 without a port-visible set pulse, so the hardware-set property leaves that bit out. The bench changes every input only on the falling clock edge. It drives the pin well apart from other activity, so the properties about flags that never drop without a selected write stay valid throughout.

// File: rtl/trap_pkg.sv
// Package: bit positions and class sizes shared by the trap flag logic.
// Assumes class-A flags occupy the lowest bits, followed by class-B flags.
package trap_pkg;
    localparam int STKUF_BIT     = 0;
    localparam int STKOF_BIT     = 1;
    localparam int NMI_BIT       = 2;
    localparam int CLASS_A_COUNT = 3;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_A    = 2'd1,
        CLS_B    = 2'd2
    } trap_class_e;
endpackage

// File: rtl/nmi_edge_sync.sv
// Module: brings an asynchronous active-low pin into the clock domain and
// emits a one-cycle pulse for each falling edge.
// Assumes STAGES >= 2; pin idles high, so the chain resets to 1.
module nmi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the pin through the synchronizer chain and keep the prior sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n};
            last_q <= sync_q[STAGES-1];
        end
    end

    // High for one cycle when the synchronized level goes from 1 to 0.
    always_comb begin
        fall_pulse = last_q & ~sync_q[STAGES-1];
    end
endmodule

// File: rtl/trap_flag_cell.sv
// Module: one trap flag. A hardware set wins over everything; otherwise a
// selected write loads the written value; otherwise the flag holds.
// Assumes wr_hit already combines the write strobe with this bit's select.
module trap_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic wr_hit,
    input  logic wr_val,
    output logic q
);
    logic q_next;

    // Choose the next value with hardware set as top priority.
    always_comb begin
        if (hw_set)
            q_next = 1'b1;
        else if (wr_hit)
            q_next = wr_val;
        else
            q_next = q;
    end

    // Hold the flag state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else
            q <= q_next;
    end
endmodule

// File: rtl/trap_pend_encode.sv
// Module: reduces the flag groups to per-class pending indications, with
// class A masking class B.
// Assumes both groups hold at least one flag.
module trap_pend_encode
    import trap_pkg::*;
#(
    parameter int NUM_A = 3,
    parameter int NUM_B = 4
) (
    input  logic [NUM_A-1:0] flags_a,
    input  logic [NUM_B-1:0] flags_b,
    output logic             pend_a,
    output logic             pend_b
);
    trap_class_e top_cls;

    // Pick the highest-priority class that has a flag set.
    always_comb begin
        if (|flags_a)
            top_cls = CLS_A;
        else if (|flags_b)
            top_cls = CLS_B;
        else
            top_cls = CLS_NONE;
    end

    // Decode the chosen class onto the two pending lines.
    always_comb begin
        pend_a = (top_cls == CLS_A);
        pend_b = (top_cls == CLS_B);
    end
endmodule

// File: rtl/trap_flag_reg.sv
// Module: trap flag register with bit-protected read-modify-write.
// Only bits selected in wr_sel change on a write; hardware sets are never
// lost. Assumes set pulses and write strobes are synchronous to clk; nmi_n
// may be asynchronous.
module trap_flag_reg
    import trap_pkg::*;
#(
    parameter int NUM_CLASSB  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              nmi_n,
    input  logic                              stk_unf_set,
    input  logic                              stk_ovf_set,
    input  logic [NUM_CLASSB-1:0]             err_set,
    input  logic                              wr_en,
    input  logic [CLASS_A_COUNT+NUM_CLASSB-1:0] wr_sel,
    input  logic [CLASS_A_COUNT+NUM_CLASSB-1:0] wr_data,
    output logic [CLASS_A_COUNT+NUM_CLASSB-1:0] rd_data,
    output logic                              pend_a,
    output logic                              pend_b
);
    localparam int W = CLASS_A_COUNT + NUM_CLASSB;

    logic         nmi_fall;
    logic [W-1:0] hw_set_vec;
    logic [W-1:0] wr_hit_vec;
    logic [W-1:0] flag_q;

    nmi_edge_sync #(.STAGES(SYNC_STAGES)) u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (nmi_n),
        .fall_pulse (nmi_fall)
    );

    // Gather every hardware set source into the flag bit order.
    always_comb begin
        hw_set_vec                 = '0;
        hw_set_vec[STKUF_BIT]      = stk_unf_set;
        hw_set_vec[STKOF_BIT]      = stk_ovf_set;
        hw_set_vec[NMI_BIT]        = nmi_fall;
        hw_set_vec[W-1:CLASS_A_COUNT] = err_set;
    end

    // Qualify the select mask with the write strobe.
    always_comb begin
        wr_hit_vec = wr_sel & {W{wr_en}};
    end

    for (genvar i = 0; i < W; i++) begin : g_flag
        trap_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (hw_set_vec[i]),
            .wr_hit (wr_hit_vec[i]),
            .wr_val (wr_data[i]),
            .q      (flag_q[i])
        );
    end

    trap_pend_encode #(.NUM_A(CLASS_A_COUNT), .NUM_B(NUM_CLASSB)) u_pend (
        .flags_a (flag_q[CLASS_A_COUNT-1:0]),
        .flags_b (flag_q[W-1:CLASS_A_COUNT]),
        .pend_a  (pend_a),
        .pend_b  (pend_b)
    );

    // Present the live flag image on the read port.
    always_comb begin
        rd_data = flag_q;
    end
endmodule

// File: rtl/trap_flag_reg_chk.sv
// Checker: temporal properties of the trap flag register, bound to the top.
module trap_flag_reg_chk #(
    parameter int NUM_CLASSB = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    stk_unf_set,
    input logic                    stk_ovf_set,
    input logic [NUM_CLASSB-1:0]   err_set,
    input logic                    wr_en,
    input logic [NUM_CLASSB+2:0]   wr_sel,
    input logic [NUM_CLASSB+2:0]   rd_data,
    input logic                    pend_a,
    input logic                    pend_b
);
    logic [NUM_CLASSB+2:0] hwv;
    assign hwv = {err_set, 1'b0, stk_ovf_set, stk_unf_set};

    // R2 R5
    hw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hwv) |=> ((rd_data & $past(hwv)) == $past(hwv)));

    // R3
    unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((~rd_data & $past(rd_data) & ~$past(wr_sel)) == '0));

    // R9
    no_write_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((~rd_data & $past(rd_data)) == '0));

    // R7
    pend_a_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_a == (|rd_data[2:0]));

    // R8
    pend_b_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_b == ((|rd_data[NUM_CLASSB+2:3]) && !pend_a));
endmodule

bind trap_flag_reg trap_flag_reg_chk #(.NUM_CLASSB(NUM_CLASSB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stk_unf_set (stk_unf_set),
    .stk_ovf_set (stk_ovf_set),
    .err_set     (err_set),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .rd_data     (rd_data),
    .pend_a      (pend_a),
    .pend_b      (pend_b)
);

// File: tb/trap_flag_reg_tb.sv
module trap_flag_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int W  = 3 + NB;
    localparam int NV = 11;

    // Entry: {wr_en, wr_sel, wr_data, hw_set (bit2 unused), expected flags}
    localparam logic [4*W:0] VEC [NV] = '{
        {1'b0, 7'b0000000, 7'b0000000, 7'b0001000, 7'b0001000}, // R2
        {1'b0, 7'b0000000, 7'b0000000, 7'b1000010, 7'b1001010}, // R2
        {1'b1, 7'b0000010, 7'b0000000, 7'b0010000, 7'b1011000}, // R3 R4
        {1'b1, 7'b1111011, 7'b0000000, 7'b0000000, 7'b0000000}, // R4
        {1'b1, 7'b0100001, 7'b0100001, 7'b0000000, 7'b0100001}, // R4
        {1'b0, 7'b1111111, 7'b0000000, 7'b0000000, 7'b0100001}, // R9
        {1'b1, 7'b0000001, 7'b0000000, 7'b0000001, 7'b0100001}, // R5
        {1'b1, 7'b0100000, 7'b0000000, 7'b0000000, 7'b0000001}, // R4
        {1'b1, 7'b1111111, 7'b1111011, 7'b0000000, 7'b1111011}, // R4
        {1'b1, 7'b1111011, 7'b0000000, 7'b1000000, 7'b1000000}, // R5
        {1'b1, 7'b1000000, 7'b0000000, 7'b0000000, 7'b0000000}  // R4
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmi_n = 1'b1;
    logic          stk_unf_set = 1'b0;
    logic          stk_ovf_set = 1'b0;
    logic [NB-1:0] err_set = '0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_sel = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          pend_a;
    logic          pend_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    trap_flag_reg #(.NUM_CLASSB(NB), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n),
        .stk_unf_set(stk_unf_set), .stk_ovf_set(stk_ovf_set), .err_set(err_set),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_data(rd_data), .pend_a(pend_a), .pend_b(pend_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_flags(input logic [W-1:0] exp, input string req);
        logic pa, pb;
        pa = |exp[2:0];
        pb = (|exp[W-1:3]) && !pa;
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s flags act=%b exp=%b", req, rd_data, exp);
        end
        checks++;
        if (pend_a !== pa || pend_b !== pb) begin
            failures++;
            $display("FAIL %s/R7/R8 pend act=%b%b exp=%b%b", req, pend_a, pend_b, pa, pb);
        end
    endtask

    // Apply inputs at the falling edge, then sample just after the next rise.
    task automatic step(input logic we, input logic [W-1:0] sel,
                        input logic [W-1:0] dat, input logic [W-1:0] hw);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = dat;
        stk_unf_set = hw[0]; stk_ovf_set = hw[1]; err_set = hw[W-1:3];
        @(posedge clk);
        #1;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        stk_unf_set = 1'b0; stk_ovf_set = 1'b0; err_set = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_flags('0, "R1"); // during reset
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        check_flags('0, "R1");

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][4*W], VEC[v][4*W-1:3*W], VEC[v][3*W-1:2*W], VEC[v][2*W-1:W]);
            check_flags(VEC[v][W-1:0], $sformatf("R2/R3/R4/R5/R9 vec%0d", v));
        end

        // R6: falling edge timing, single set, rising edge ignored
        @(negedge clk) nmi_n = 1'b0;
        idle(2);
        check_flags(7'b0000000, "R6 early");
        idle(1);
        check_flags(7'b0000100, "R6 set");
        step(1'b1, 7'b0000100, 7'b0000000, 7'b0000000);
        check_flags(7'b0000000, "R6 cleared");
        idle(5);
        check_flags(7'b0000000, "R6 held low");
        @(negedge clk) nmi_n = 1'b1;
        idle(5);
        check_flags(7'b0000000, "R6 rising");

        // R8 alone then masked by class A (R7)
        step(1'b0, '0, '0, 7'b0100000);
        check_flags(7'b0100000, "R8 only B");
        step(1'b0, '0, '0, 7'b0000010);
        check_flags(7'b0100010, "R7 A masks B");

        // R1: reset mid-operation clears everything
        @(negedge clk) rst_n = 1'b0;
        idle(1);
        check_flags('0, "R1 mid");
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        check_flags('0, "R1 release");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule